// File: doc/BRIEF.md
# Address Interlock Detector

This block sits beside the address-formation stage of a dual-issue integer pipeline. Each cycle it may accept a group of decoded instruction descriptors, one per issue lane. For every lane it decides whether the address the instruction needs depends on a register that the group issued in the cycle just before wrote. If it does, one bubble cycle has to be inserted before that address can be formed. The block reports which lanes caused the bubble and raises a one-cycle group stall flag. It also keeps a saturating count of the bubbles it has inserted.

The stack pointer gets special treatment. Push, pop and call adjust it through a predictor, so such an adjustment never makes the next instruction wait. A return, and any explicit write to the stack pointer by an ordinary instruction, make the next stack-relative address wait. Dependencies between lanes of the same group are not interlocks. Only the previous cycle's writers count, and any cycle without an accepted group, including the bubble itself, ages every pending write out.

Top module: `addr_interlock_det`

## Requirements
- R1: While synchronous reset `rst` is high, and after it, until a stall occurs: `stallFlag` = 0, `stallLanes` = 0, `stallCount` = 0 and `inReady` = 1.
- R2: Each lane descriptor is 19 bits, with lane 0 in the low bits. Bits 18:16 hold the operation class: load=0, store=1, address-compute=2, push=3, pop=4, call=5, return=6, other=7. Bit 15 is the base-use flag and bits 14:12 the base register. Bit 11 is the index-use flag and bits 10:8 the index register. Bits 7:0 are a mask of the registers written. A load or store whose used base or index register was written by the group accepted in the immediately preceding cycle sets its bit in `stallLanes` one cycle after acceptance.
- R3: An address-compute operation (class 2) is an address consumer and stalls under the same rule as a load.
- R4: Class "other" is not an address consumer. Its base and index fields are ignored and it never stalls.
- R5: A write made two or more cycles earlier never causes a stall. Any cycle in which no group is accepted clears all pending writes.
- R6: A write by one lane never stalls another lane of the same group.
- R7: Push, pop, call and return (classes 3 to 6) read register 4, the stack pointer. They stall if the previous group wrote register 4 through an instruction of class load, store, address-compute or other.
- R8: The register-4 write of a push, pop or call is predicted and makes no following instruction stall. The other registers those instructions write are still tracked.
- R9: A return counts as an explicit register-4 write, whatever its write mask says. Any stack operation, or any consumer using register 4, in the next cycle stalls.
- R10: `stallFlag` is the OR of the lanes' stall bits. It is high for exactly one cycle, and `inReady` is low during that cycle. A group offered while `inReady` is low is not accepted and has no effect.
- R11: `stallCount` rises by one for every group that stalls, counting one per group even when both lanes stall. It holds at all-ones of its `CNT_W` bits (16 by default), and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A descriptor group is offered |
| inReady | output | 1 | The group is accepted when this and inValid are both high |
| inDesc | input | LANES*19 (38) | Descriptor group, lane 0 in the low bits |
| stallFlag | output | 1 | One-cycle bubble indication for the last accepted group |
| stallLanes | output | LANES (2) | Lanes of the last accepted group that needed the bubble |
| stallCount | output | CNT_W (16) | Saturating count of inserted bubbles |

## Verification
The bench aims at the stack pointer cases. Back-to-back pushes and a call followed by a return must pass freely. A design that did not split predicted writes from explicit ones would stall there, and one that missed the return's implicit write would let a following pop or stack-based load go through without a bubble. It also targets the ageing of writes across an idle or bubble cycle, same-group dependencies, and class "other" with matching register fields. A wrong design would show bubbles in those cases where none are due. A group offered during the bubble, two lanes stalling together, and the counter meeting its ceiling catch designs that accept during the bubble, count per lane, or wrap around.

// File: rtl/aid_pkg.sv
package aid_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_LEA   = 3'd2,
    OP_PUSH  = 3'd3,
    OP_POP   = 3'd4,
    OP_CALL  = 3'd5,
    OP_RET   = 3'd6,
    OP_OTHER = 3'd7
  } aid_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;  // group taken this cycle
    logic bump;    // group taken and needs a bubble
  } aid_strobe_t;

endpackage

// File: rtl/aid_datapath.sv
module aid_datapath
  import aid_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int NREG   = 8,
  parameter int SP_IDX = 4,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANES*(3+2*($clog2(NREG)+1)+NREG)-1:0] laneDesc,
  input  aid_strobe_t                   strb,
  output logic [LANES-1:0]              laneHit,
  output logic [LANES-1:0]              stallLanes,
  output logic [CNT_W-1:0]              stallCount
);
  localparam int REG_W = $clog2(NREG);
  localparam int DW    = 3 + 2 * (REG_W + 1) + NREG;
  localparam int IDX_LO  = NREG;
  localparam int BASE_LO = NREG + REG_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NREG-1:0] hotQ;
  logic [NREG-1:0] hotNext;
  logic [LANES-1:0][NREG-1:0] laneWr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0]    d;
    aid_op_e          op;
    logic             baseUse, idxUse, consumer, stackOp, hit;
    logic [REG_W-1:0] baseReg, idxReg;
    logic [NREG-1:0]  wr;

    assign d = laneDesc[g*DW +: DW];

    always_comb begin
      op       = aid_op_e'(d[DW-1 -: 3]);
      baseUse  = d[BASE_LO + REG_W];
      baseReg  = d[BASE_LO +: REG_W];
      idxUse   = d[IDX_LO + REG_W];
      idxReg   = d[IDX_LO +: REG_W];
      consumer = op inside {OP_LOAD, OP_STORE, OP_LEA};
      stackOp  = op inside {OP_PUSH, OP_POP, OP_CALL, OP_RET};
      hit = (consumer && ((baseUse && hotQ[baseReg]) || (idxUse && hotQ[idxReg])))
          || (stackOp && hotQ[SP_IDX]);
      wr = d[NREG-1:0];
      if (op inside {OP_PUSH, OP_POP, OP_CALL}) wr[SP_IDX] = 1'b0;  // predicted
      if (op == OP_RET) wr[SP_IDX] = 1'b1;                           // explicit
    end

    assign laneHit[g] = hit;
    assign laneWr[g]  = wr;
  end

  always_comb begin
    hotNext = '0;
    for (int i = 0; i < LANES; i++) hotNext = hotNext | laneWr[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hotQ       <= '0;
      stallLanes <= '0;
      stallCount <= '0;
    end else begin
      hotQ       <= strb.accept ? hotNext : '0;
      stallLanes <= strb.accept ? laneHit : '0;
      if (strb.bump && stallCount != CNT_MAX) stallCount <= stallCount + 1'b1;
    end
  end

  // R11: one step per stalled group
  p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
    (strb.bump && stallCount != CNT_MAX) |=> stallCount == $past(stallCount) + 1'b1);
  // R11: no change without a stalled group
  p_count_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !strb.bump |=> $stable(stallCount));
  // R11: ceiling holds
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    stallCount == CNT_MAX |=> stallCount == CNT_MAX);

endmodule

// File: rtl/aid_control.sv
module aid_control
  import aid_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [LANES-1:0] laneHit,
  output logic             inReady,
  output logic             stallFlag,
  output aid_strobe_t      strb
);
  logic stallQ;

  assign inReady = !stallQ;

  always_comb begin
    strb.accept = inValid && inReady;
    strb.bump   = strb.accept && (|laneHit);
  end

  always_ff @(posedge clk) begin
    if (rst) stallQ <= 1'b0;
    else     stallQ <= strb.bump;
  end

  assign stallFlag = stallQ;

  // R10: bubble lasts a single cycle
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    stallFlag |=> !stallFlag);
  // R10: a bubble only follows an offered group
  p_flag_needs_input_r10: assert property (@(posedge clk) disable iff (rst)
    stallFlag |-> $past(inValid));

endmodule

// File: rtl/addr_interlock_det.sv
module addr_interlock_det
  import aid_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int NREG   = 8,
  parameter int SP_IDX = 4,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [LANES*(3+2*($clog2(NREG)+1)+NREG)-1:0] inDesc,
  output logic                   stallFlag,
  output logic [LANES-1:0]       stallLanes,
  output logic [CNT_W-1:0]       stallCount
);
  aid_strobe_t      strb;
  logic [LANES-1:0] laneHit;

  aid_control #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .laneHit(laneHit),
    .inReady(inReady), .stallFlag(stallFlag), .strb(strb)
  );

  aid_datapath #(.LANES(LANES), .NREG(NREG), .SP_IDX(SP_IDX), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .laneDesc(inDesc), .strb(strb),
    .laneHit(laneHit), .stallLanes(stallLanes), .stallCount(stallCount)
  );

endmodule

// File: tb/addr_interlock_det_bench.sv
module addr_interlock_det_bench;
  localparam int CW = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst = 1, inValid = 0;
  logic inReady, stallFlag;
  logic [37:0] inDesc = '0;
  logic [1:0] stallLanes;
  logic [CW-1:0] stallCount;

  int total = 0, bad = 0;
  logic [7:0] refHot = 0;
  logic refFlag = 0;
  logic [1:0] refLanes = 0;
  int refCount = 0;

  always #2 clk = ~clk;

  addr_interlock_det #(.CNT_W(CW)) u_addr_interlock_det (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inDesc(inDesc),
    .stallFlag(stallFlag), .stallLanes(stallLanes), .stallCount(stallCount)
  );

  function automatic logic [18:0] mk(int op, bit bu, int br, bit iu, int ir, logic [7:0] wm);
    return {op[2:0], bu, br[2:0], iu, ir[2:0], wm};
  endfunction
  localparam logic [18:0] NOP = {3'd7, 16'h0};

  task automatic chk(string req);
    total++;
    if (stallFlag !== refFlag || stallLanes !== refLanes || stallCount !== refCount[CW-1:0]
        || inReady !== !refFlag) begin
      bad++;
      $display("FAIL %s: flag=%0b lanes=%b cnt=%0d rdy=%0b exp flag=%0b lanes=%b cnt=%0d rdy=%0b",
               req, stallFlag, stallLanes, stallCount, inReady, refFlag, refLanes, refCount, !refFlag);
    end
  endtask

  // behavioural reference: one accepted group per call
  task automatic cyc(bit v, logic [18:0] l1, logic [18:0] l0, string req, bit doChk = 1);
    logic [18:0] ln [2];
    logic [1:0] hits = 0;
    logic [7:0] wrAll = 0;
    bit acc;
    inValid = v; inDesc = {l1, l0};
    ln[0] = l0; ln[1] = l1;
    acc = v && !refFlag;
    for (int k = 0; k < 2; k++) begin
      int op = ln[k][18:16];
      logic [7:0] w = ln[k][7:0];
      bit h = 0;
      if (op <= 2) begin
        if (ln[k][15] && refHot[ln[k][14:12]]) h = 1;
        if (ln[k][11] && refHot[ln[k][10:8]]) h = 1;
      end
      if (op >= 3 && op <= 6 && refHot[4]) h = 1;
      if (op >= 3 && op <= 5) w[4] = 0;
      if (op == 6) w[4] = 1;
      hits[k] = h;
      wrAll |= w;
    end
    @(posedge clk); @(negedge clk);
    refFlag  = acc && (hits != 0);
    refLanes = acc ? hits : 2'b00;
    refHot   = acc ? wrAll : 8'h00;
    if (refFlag && refCount < CMAX) refCount++;
    if (doChk) chk(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R1");
    rst = 0;
    cyc(0, NOP, NOP, "R1");
    // R2 base hit
    cyc(1, NOP, mk(7,0,0,0,0,8'h02), "R2");
    cyc(1, NOP, mk(0,1,1,0,0,8'h00), "R2");
    // R10 group offered during bubble is ignored
    cyc(1, NOP, mk(0,1,1,0,0,8'h00), "R10");
    cyc(1, NOP, mk(0,1,1,0,0,8'h00), "R10");
    // R2 index hit on lane1 store
    cyc(1, mk(7,0,0,0,0,8'h08), NOP, "R2");
    cyc(1, mk(1,0,0,1,3,8'h00), NOP, "R2");
    cyc(0, NOP, NOP, "R2");
    // R2 unused base field ignored
    cyc(1, NOP, mk(7,0,0,0,0,8'h02), "R2");
    cyc(1, NOP, mk(0,0,1,1,2,8'h00), "R2");
    // R3 address compute
    cyc(1, NOP, mk(7,0,0,0,0,8'h40), "R3");
    cyc(1, NOP, mk(2,1,6,0,0,8'h00), "R3");
    cyc(0, NOP, NOP, "R3");
    // R4 other ignores fields
    cyc(1, NOP, mk(7,0,0,0,0,8'h01), "R4");
    cyc(1, mk(7,1,0,1,0,8'h00), mk(7,1,0,1,0,8'h00), "R4");
    // R5 aged write
    cyc(1, NOP, mk(7,0,0,0,0,8'h04), "R5");
    cyc(0, NOP, NOP, "R5");
    cyc(1, NOP, mk(0,1,2,0,0,8'h00), "R5");
    // R6 same-group dependency
    cyc(1, mk(0,1,5,0,0,8'h00), mk(7,0,0,0,0,8'h20), "R6");
    cyc(0, NOP, NOP, "R6");
    // R7 explicit stack pointer write
    cyc(1, NOP, mk(7,0,0,0,0,8'h10), "R7");
    cyc(1, NOP, mk(3,0,0,0,0,8'h10), "R7");
    cyc(0, NOP, NOP, "R7");
    cyc(1, NOP, mk(0,1,1,0,0,8'h10), "R7");
    cyc(1, NOP, mk(4,0,0,0,0,8'h11), "R7");
    cyc(0, NOP, NOP, "R7");
    // R8 predicted stack adjustments
    cyc(1, NOP, mk(3,0,0,0,0,8'h10), "R8");
    cyc(1, mk(3,0,0,0,0,8'h10), mk(3,0,0,0,0,8'h10), "R8");
    cyc(1, NOP, mk(5,0,0,0,0,8'h10), "R8");
    cyc(1, NOP, mk(0,1,4,0,0,8'h00), "R8");
    cyc(1, NOP, mk(4,0,0,0,0,8'h50), "R8");
    cyc(1, NOP, mk(0,1,6,0,0,8'h00), "R8");
    cyc(0, NOP, NOP, "R8");
    // R9 return
    cyc(1, NOP, mk(5,0,0,0,0,8'h10), "R9");
    cyc(1, NOP, mk(6,0,0,0,0,8'h00), "R9");
    cyc(1, NOP, mk(4,0,0,0,0,8'h11), "R9");
    cyc(0, NOP, NOP, "R9");
    cyc(1, NOP, mk(6,0,0,0,0,8'h00), "R9");
    cyc(1, NOP, mk(0,0,0,1,4,8'h00), "R9");
    cyc(0, NOP, NOP, "R9");
    // R10 both lanes stall, one count
    cyc(1, mk(7,0,0,0,0,8'h80), mk(6,0,0,0,0,8'h00), "R10");
    cyc(1, mk(2,1,7,0,0,8'h00), mk(3,0,0,0,0,8'h10), "R10");
    cyc(0, NOP, NOP, "R10");
    // R11 saturation
    for (int n = 0; n < CMAX + 5; n++) begin
      cyc(1, NOP, mk(7,0,0,0,0,8'h02), "R11", 0);
      cyc(1, NOP, mk(0,1,1,0,0,8'h00), "R11", 0);
      cyc(0, NOP, NOP, "R11", 0);
    end
    chk("R11");
    total++;
    if (stallCount !== CMAX[CW-1:0]) begin
      bad++;
      $display("FAIL R11: cnt=%0d exp %0d", stallCount, CMAX);
    end
    // R1/R11 reset clears count
    rst = 1;
    @(posedge clk); @(negedge clk);
    refCount = 0; refFlag = 0; refLanes = 0; refHot = 0;
    chk("R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule